// File: doc/BRIEF.md
# Flash Write-Completion Poller

This engine runs on the host side of a parallel NOR-style flash. It decides when an internal program or erase has finished, which the device completes on its own time. The controller first issues the write command sequence itself. It then pulses `start` with the location that was written, the data that should end up there, and a detection method. From that point the engine drives the chip-enable, output-enable and address lines of a plain read port and reads the location again and again until the device reports that it has finished.

Two detection methods are supported. In complement polling, bit 7 of a status read holds the inverse of the expected data's bit 7 for as long as the device is busy. In toggle detection, bit 6 flips between consecutive reads while the device is busy and stops flipping once it is idle. Completion happens asynchronously to the host, so the read that first reports completion can return a byte that differs from the expected value. When that happens, the engine reads the same location twice more. It declares success only if both of those extra reads return exactly the expected byte. A programmable limit on the number of status reads prevents the engine from waiting forever.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `timeout`, `flash_ce` and `flash_oe` are all 0.
- R2: `start` is accepted only while `busy` is 0. An accepted start latches the address, expected data and mode, raises `busy`, and clears `pass` and `timeout`. A `start` that arrives while `busy` is 1 changes neither the reads issued nor the result.
- R3: After an accepted start, no read strobe is issued while `flash_we_n` is 0. Polling begins only once `flash_we_n` is 1.
- R4: Every read asserts `flash_ce` and `flash_oe` together for exactly `strobe_len` clock cycles, with a value of 0 treated as 1. The engine samples `flash_dq` in the last of those cycles, drives the latched address on `flash_addr` throughout, and then holds both strobes low for at least one cycle.
- R5: When `start_mode` is 0 (complement polling), a read whose bit 7 equals bit 7 of the expected data signals completion. Any other read signals busy.
- R6: When `start_mode` is 1 (toggle detection), the first read serves only as a reference. Each later read signals busy if its bit 6 differs from bit 6 of the previous read, and signals completion if bit 6 is unchanged.
- R7: If the read that signals completion equals the expected byte in all bits, the operation ends with `pass`=1 and no further reads are made.
- R8: If the read that signals completion differs from the expected byte, exactly two more reads of the same location follow. `pass` is 1 only if both of those reads equal the expected byte. Otherwise the operation ends with `pass`=0 and `timeout`=0.
- R9: Let n be the number of status reads made so far in the operation, counting the reference read. If a read signals busy and n is at least `max_polls`, the operation ends with `timeout`=1 and `pass`=0. A `max_polls` of 0 behaves as 1.
- R10: `done` is a pulse exactly one cycle wide, and `busy` falls in the same cycle. `pass` and `timeout` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted when idle |
| start_addr | input | ADDR_W | Location to poll |
| start_data | input | DATA_W | Data expected at the location |
| start_mode | input | 1 | 0 = complement polling, 1 = toggle detection |
| strobe_len | input | STROBE_W | Strobe length per read, in clocks (0 acts as 1) |
| max_polls | input | POLL_W | Status read limit (0 acts as 1) |
| flash_we_n | input | 1 | Write-enable strobe of the flash, observed only |
| flash_dq | input | DATA_W | Flash data bus |
| flash_ce | output | 1 | Chip enable for reads, active high |
| flash_oe | output | 1 | Output enable for reads, active high |
| flash_addr | output | ADDR_W | Read address |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Write confirmed |
| timeout | output | 1 | Read limit reached without completion |

## Verification
The hardest case to reach is a status read that reports completion while carrying a wrong byte, because a real device produces it only when completion coincides with a read. The bench models the flash as a script indexed by read number. That lets it place such a read at a chosen position and follow it with two clean verify reads, or with one clean and one bad. It also places completion exactly on the last read the limit allows, and one read beyond it. Each run additionally holds the write strobe low after start and injects a conflicting start while the engine is busy.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_WE = 2'd1,
    ST_POLL    = 2'd2,
    ST_VERIFY  = 2'd3
  } eng_state_t;

  typedef enum logic [1:0] {
    RP_IDLE   = 2'd0,
    RP_STROBE = 2'd1,
    RP_GAP    = 2'd2
  } rp_state_t;

  typedef enum logic {
    MODE_COMPLEMENT = 1'b0,
    MODE_TOGGLE     = 1'b1
  } poll_mode_t;

  localparam int COMP_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/fdp_read_port.sv
module fdp_read_port #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int STROBE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [STROBE_W-1:0] len,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [DATA_W-1:0]   dq,
  output logic                ready,
  output logic                ce,
  output logic                oe,
  output logic [ADDR_W-1:0]   addr,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  import fdp_pkg::*;

  rp_state_t           st;
  logic [STROBE_W-1:0] remain;
  logic [STROBE_W-1:0] first_remain;

  assign first_remain = (len == '0) ? '0 : len - 1'b1;
  assign ready        = (st == RP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RP_IDLE;
      remain   <= '0;
      ce       <= 1'b0;
      oe       <= 1'b0;
      addr     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        RP_IDLE: begin
          if (go) begin
            ce     <= 1'b1;
            oe     <= 1'b1;
            addr   <= addr_in;
            remain <= first_remain;
            st     <= RP_STROBE;
          end
        end
        RP_STROBE: begin
          if (remain == '0) begin
            ce       <= 1'b0;
            oe       <= 1'b0;
            rd_valid <= 1'b1;
            rd_data  <= dq;
            st       <= RP_GAP;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: st <= RP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdp_judge.sv
module fdp_judge #(
  parameter int DATA_W = 8
) (
  input  logic              mode,
  input  logic [DATA_W-1:0] expect_data,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              have_ref,
  input  logic              prev_tog,
  output logic              is_busy,
  output logic              is_complete,
  output logic              exact
);
  import fdp_pkg::*;

  always_comb begin
    is_busy     = 1'b0;
    is_complete = 1'b0;
    if (mode == MODE_COMPLEMENT) begin
      is_complete = (rd_data[COMP_BIT] == expect_data[COMP_BIT]);
      is_busy     = !is_complete;
    end else if (have_ref) begin
      is_busy     = (rd_data[TOGGLE_BIT] != prev_tog);
      is_complete = !is_busy;
    end
    exact = (rd_data == expect_data);
  end
endmodule

// File: rtl/fdp_limit_counter.sv
module fdp_limit_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         at_limit
);
  logic [W:0] count;
  logic [W:0] eff_limit;

  assign eff_limit = (limit == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, limit};
  assign at_limit  = (count + 1'b1) >= eff_limit;

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc && !count[W]) count <= count + 1'b1;
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int STROBE_W = 4,
  parameter int POLL_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [DATA_W-1:0]   start_data,
  input  logic                start_mode,
  input  logic [STROBE_W-1:0] strobe_len,
  input  logic [POLL_W-1:0]   max_polls,
  input  logic                flash_we_n,
  input  logic [DATA_W-1:0]   flash_dq,
  output logic                flash_ce,
  output logic                flash_oe,
  output logic [ADDR_W-1:0]   flash_addr,
  output logic                busy,
  output logic                done,
  output logic                pass,
  output logic                timeout
);
  import fdp_pkg::*;

  eng_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              mode_q;
  logic              have_ref;
  logic              prev_tog;
  logic              inflight;
  logic              ver_second;
  logic              ver_bad;

  logic              rp_ready;
  logic              rd_go;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              j_busy;
  logic              j_complete;
  logic              j_exact;
  logic              at_limit;
  logic              accept;

  assign accept = (st == ST_IDLE) && start;
  assign rd_go  = ((st == ST_POLL) || (st == ST_VERIFY)) && rp_ready && !inflight;

  fdp_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_W(STROBE_W)
  ) i_port (
    .clk(clk), .rst(rst), .go(rd_go), .len(strobe_len), .addr_in(addr_q),
    .dq(flash_dq), .ready(rp_ready), .ce(flash_ce), .oe(flash_oe),
    .addr(flash_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  fdp_judge #(.DATA_W(DATA_W)) i_judge (
    .mode(mode_q), .expect_data(exp_q), .rd_data(rd_data),
    .have_ref(have_ref), .prev_tog(prev_tog),
    .is_busy(j_busy), .is_complete(j_complete), .exact(j_exact)
  );

  fdp_limit_counter #(.W(POLL_W)) i_limit (
    .clk(clk), .rst(rst), .clr(accept),
    .inc(rd_valid && (st == ST_POLL)), .limit(max_polls), .at_limit(at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      addr_q     <= '0;
      exp_q      <= '0;
      mode_q     <= 1'b0;
      have_ref   <= 1'b0;
      prev_tog   <= 1'b0;
      inflight   <= 1'b0;
      ver_second <= 1'b0;
      ver_bad    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            addr_q     <= start_addr;
            exp_q      <= start_data;
            mode_q     <= start_mode;
            have_ref   <= 1'b0;
            inflight   <= 1'b0;
            ver_second <= 1'b0;
            ver_bad    <= 1'b0;
            pass       <= 1'b0;
            timeout    <= 1'b0;
            busy       <= 1'b1;
            st         <= ST_WAIT_WE;
          end
        end
        ST_WAIT_WE: begin
          if (flash_we_n) st <= ST_POLL;
        end
        ST_POLL: begin
          if (rd_go) inflight <= 1'b1;
          if (rd_valid) begin
            inflight <= 1'b0;
            have_ref <= 1'b1;
            prev_tog <= rd_data[TOGGLE_BIT];
            if (j_complete) begin
              if (j_exact) begin
                pass <= 1'b1;
                done <= 1'b1;
                busy <= 1'b0;
                st   <= ST_IDLE;
              end else begin
                st <= ST_VERIFY;
              end
            end else if (j_busy && at_limit) begin
              timeout <= 1'b1;
              done    <= 1'b1;
              busy    <= 1'b0;
              st      <= ST_IDLE;
            end
          end
        end
        ST_VERIFY: begin
          if (rd_go) inflight <= 1'b1;
          if (rd_valid) begin
            inflight <= 1'b0;
            if (ver_second) begin
              pass <= !ver_bad && j_exact;
              done <= 1'b1;
              busy <= 1'b0;
              st   <= ST_IDLE;
            end else begin
              ver_second <= 1'b1;
              ver_bad    <= !j_exact;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              flash_ce,
  input logic              flash_oe,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              timeout
);
  AST_CE_OE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    flash_ce == flash_oe); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (flash_oe && $past(flash_oe)) |-> $stable(flash_addr)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !flash_oe); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(pass) && $stable(timeout))); // R10
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pass && timeout)); // R9
endmodule

bind flash_done_poller fdp_checker #(.ADDR_W(ADDR_W)) i_fdp_checker (
  .clk(clk), .rst(rst), .start(start), .flash_ce(flash_ce), .flash_oe(flash_oe),
  .flash_addr(flash_addr), .busy(busy), .done(done), .pass(pass), .timeout(timeout)
);

// File: tb/test_flash_done_poller.sv
`timescale 1ns/1ps
module test_flash_done_poller;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int STROBE_W = 4;
  localparam int POLL_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [DATA_W-1:0] start_data = '0;
  logic start_mode = 1'b0;
  logic [STROBE_W-1:0] strobe_len = 4'd1;
  logic [POLL_W-1:0] max_polls = 16'd1;
  logic flash_we_n = 1'b1;
  logic [DATA_W-1:0] flash_dq;
  logic flash_ce, flash_oe, busy, done, pass, timeout;
  logic [ADDR_W-1:0] flash_addr;

  always #2 clk = ~clk;

  flash_done_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_W(STROBE_W), .POLL_W(POLL_W))
  i_flash_done_poller (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .start_data(start_data),
    .start_mode(start_mode), .strobe_len(strobe_len), .max_polls(max_polls),
    .flash_we_n(flash_we_n), .flash_dq(flash_dq), .flash_ce(flash_ce), .flash_oe(flash_oe),
    .flash_addr(flash_addr), .busy(busy), .done(done), .pass(pass), .timeout(timeout)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // scenario description for the flash model
  int s_mode = 0, s_nbusy = 0, s_kind = 0;
  logic [7:0] s_exp = 8'h00;
  logic [ADDR_W-1:0] s_addr = '0;
  int exp_len = 1;

  int rd_idx = 0;
  logic clr_idx = 1'b0;
  logic oe_q = 1'b0;

  // read k of the scripted flash (kind: 0 clean, 1 conflict then good, 2 conflict then bad, 3 never done)
  function automatic logic [7:0] flash_val(int k, int mode, int nbusy, int kind, logic [7:0] e);
    int c;
    c = (mode != 0) ? nbusy + 1 : nbusy;
    if (kind == 3) begin
      if (mode == 0) return e ^ 8'h80 ^ {1'b0, 7'(k * 3)};
      return e ^ {1'b0, k[0], 6'd0};
    end
    if (k < c) begin
      if (mode == 0) return e ^ 8'h80 ^ {1'b0, 7'(k * 3)};
      return e ^ {1'b0, 1'((c - 1 - k) & 1), 6'd0};
    end
    if (k == c) return (kind == 0) ? e : (e ^ 8'h01);
    if (k == c + 2 && kind == 2) return e ^ 8'h02;
    return e;
  endfunction

  assign flash_dq = flash_val(rd_idx, s_mode, s_nbusy, s_kind, s_exp);

  always @(posedge clk) begin
    oe_q <= flash_oe;
    if (clr_idx) rd_idx <= 0;
    else if (oe_q && !flash_oe) rd_idx <= rd_idx + 1;
  end

  // strobe shape and address monitor (R4)
  int mon_err = 0;
  int run_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (flash_ce != flash_oe) mon_err = mon_err + 1;
      if (flash_oe) begin
        run_len = run_len + 1;
        if (flash_addr != s_addr) mon_err = mon_err + 1;
      end else if (run_len != 0) begin
        if (run_len != exp_len) mon_err = mon_err + 1;
        run_len = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks = checks + 1;
    if (act != expv) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // requirement-level prediction of one operation
  task automatic predict(input int mode, input int nbusy, input int kind, input logic [7:0] e,
                         input int maxp, output int reads, output int p, output int t);
    int lim;
    int have_ref;
    logic prev6;
    logic [7:0] d;
    logic bsy, cmp;
    lim = (maxp == 0) ? 1 : maxp;
    have_ref = 0; prev6 = 1'b0;
    reads = 0; p = 0; t = 0;
    for (int k = 0; k < 200; k++) begin
      d = flash_val(k, mode, nbusy, kind, e);
      bsy = 1'b0; cmp = 1'b0;
      if (mode == 0) begin
        cmp = (d[7] == e[7]); bsy = !cmp;
      end else if (have_ref != 0) begin
        bsy = (d[6] != prev6); cmp = !bsy;
      end
      have_ref = 1; prev6 = d[6];
      if (cmp) begin
        if (d == e) begin reads = k + 1; p = 1; end
        else begin
          reads = k + 3;
          p = (flash_val(k + 1, mode, nbusy, kind, e) == e &&
               flash_val(k + 2, mode, nbusy, kind, e) == e) ? 1 : 0;
        end
        return;
      end
      if (bsy && (k + 1) >= lim) begin reads = k + 1; t = 1; return; end
    end
  endtask

  task automatic run_one(input int mode, input int nbusy, input int kind, input int maxp,
                         input int slen, input logic [7:0] e, input logic [ADDR_W-1:0] a);
    int er, ep, et, wait_cyc, wegate_err, hp, ht;
    predict(mode, nbusy, kind, e, maxp, er, ep, et);
    @(negedge clk);
    s_mode = mode; s_nbusy = nbusy; s_kind = kind; s_exp = e; s_addr = a;
    exp_len = (slen == 0) ? 1 : slen;
    strobe_len = STROBE_W'(slen); max_polls = POLL_W'(maxp);
    mon_err = 0; wegate_err = 0;
    flash_we_n = 1'b0;
    start = 1'b1; start_addr = a; start_data = e; start_mode = mode[0];
    clr_idx = 1'b1;
    @(negedge clk);
    start = 1'b0; clr_idx = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    check("R2 result cleared", int'(pass) + int'(timeout), 0);
    for (int i = 0; i < nbusy + 3; i++) begin
      if (i == 1) begin
        // conflicting start while busy must be ignored (R2)
        start = 1'b1; start_data = ~e; start_mode = ~mode[0]; start_addr = ~a;
      end else start = 1'b0;
      if (flash_oe) wegate_err++;
      @(negedge clk);
    end
    start = 1'b0;
    if (flash_oe) wegate_err++;
    check("R3 no strobe before write strobe high", wegate_err, 0);
    flash_we_n = 1'b1;
    wait_cyc = 0;
    while (!done && wait_cyc < 3000) begin @(negedge clk); wait_cyc++; end
    check("R10 done seen", int'(done), 1);
    check("R10 busy falls with done", int'(busy), 0);
    check(mode == 0 ? "R5 R7 R8 R9 read count" : "R6 R7 R8 R9 read count", rd_idx, er);
    check(kind == 0 ? "R7 pass" : "R8 pass", int'(pass), ep);
    check("R9 timeout", int'(timeout), et);
    hp = int'(pass); ht = int'(timeout);
    @(negedge clk);
    check("R10 done one cycle", int'(done), 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R10 result held", int'(pass) * 2 + int'(timeout), hp * 2 + ht);
    check("R4 strobe shape and address", mon_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset result", int'(pass) + int'(timeout), 0);
    check("R1 reset strobes", int'(flash_ce) + int'(flash_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", int'(busy) + int'(flash_oe), 0);
    for (int mode = 0; mode < 2; mode++)
      for (int nbusy = 0; nbusy < 4; nbusy++)
        for (int kind = 0; kind < 4; kind++)
          for (int mv = 0; mv < 3; mv++) begin
            int c, maxp, slen;
            logic [7:0] e;
            c = (mode != 0) ? nbusy + 2 : nbusy + 1;
            maxp = (mv == 0) ? c - 1 : (mv == 1) ? c : 12;
            slen = (nbusy + kind + mv) % 4;
            e = 8'(8'h35 + (mode * 97) + (nbusy * 37) + (kind * 11) + (mv * 71));
            run_one(mode, nbusy, kind, maxp, slen, e, ADDR_W'(20'h1A5C3 + nbusy * 257 + kind));
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule